// File: doc/BRIEF.md
# Set-associative block cache with least-recently-used replacement

This block is a small read-only cache of block numbers with four block frames. A requester presents a block address and holds it until the cache answers. If the block is resident, the stored word is returned without touching memory. Otherwise the cache fetches the word from a backing memory through a request/acknowledge handshake, installs it in a frame, and returns it in the cycle the acknowledge arrives. The parameter `WAYS` sets the organisation of the four frames: 1 gives four direct-mapped sets, 2 gives two sets of two ways, and 4 gives one fully associative set.

A set is chosen by the low-order bits of the block address, which is the block number modulo the number of sets. The remaining high-order bits are kept as the tag. Every way of the selected set is compared at the same time. When a set has a free frame, a fill uses it. When the set is full, the fill evicts the way that was used least recently. With two ways, one bit per set tracks recency. With four ways, a per-set age ordering tracks it.

The controller has three states. `ST_IDLE` waits for a request and moves to `ST_TAG` when `req_valid` is high, latching the address. `ST_TAG` compares the tags. On a hit it answers and returns to `ST_IDLE`. On a miss it moves to `ST_FILL`. `ST_FILL` holds the memory request until `mem_ack`, then writes the frame, answers and returns to `ST_IDLE`. A running count of fills is always visible on `miss_count`.

Top module: `lru_cache`

## Requirements
- R1: After reset every frame is invalid, `rsp_hit` and `mem_req` are low and `miss_count` is zero. The first access to any block therefore misses.
- R2: The set index is the block address modulo the number of sets (its low-order bits). The tag is the rest of the address. Two blocks that share a set but differ in tag never hit on each other.
- R3: A request for a resident block raises `rsp_hit` in the cycle after the request is accepted, with `rsp_data` equal to the word installed for that block, and `mem_req` stays low.
- R4: On a miss, `mem_req` rises with `mem_addr` equal to the block address and both stay steady until `mem_ack`. In the acknowledge cycle `rsp_hit` is high and `rsp_data` equals `mem_data`. Before that cycle `rsp_hit` stays low.
- R5: A fill into a set that has an invalid way uses an invalid way and evicts nothing.
- R6: A fill into a full set evicts the least recently used way of that set, where both hits and fills count as uses.
- R7: `miss_count` increases by exactly one for each completed fill and is otherwise unchanged.
- R8: From reset, the block sequence 0, 8, 0, 6, 8 misses five times with `WAYS`=1. With `WAYS`=2 it gives miss, miss, hit, miss, miss. With `WAYS`=4 it gives miss, miss, hit, miss, hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; held until `rsp_hit` |
| req_addr | input | ADDR_W | Block address of the request |
| rsp_hit | output | 1 | Response this cycle; `rsp_data` valid |
| rsp_data | output | DATA_W | Returned word |
| mem_req | output | 1 | Fill request to backing memory |
| mem_addr | output | ADDR_W | Block address of the fill |
| mem_ack | input | 1 | Memory data valid this cycle |
| mem_data | input | DATA_W | Fill word from memory |
| miss_count | output | CNT_W | Number of fills completed since reset |

## Verification
The hardest case to reach is an eviction in a full set in which the victim depends on a hit that came between two fills. It can only be reached through sequences that revisit a set several times in a particular order. The stimulus first runs the fixed 0, 8, 0, 6, 8 sequence on three instances, one per organisation. It then drives a pseudo-random stream confined mostly to sixteen block numbers, so sets fill, get re-hit and get evicted again and again. A queue-based recency model in the bench predicts every hit or miss and every fill count. The memory latency varies with the address so that the fill wait changes from access to access.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_FILL = 2'd2
    } cache_state_e;
endpackage

// File: rtl/tag_match.sv
module tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 7,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           probe,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       any_hit
);
    logic [WAYS-1:0] match;

    // one comparator per way, all in parallel
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w] == probe);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit = |match;

    // R2: a block is never resident in two ways of one set
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/repl_policy.sv
module repl_policy #(
    parameter int WAYS  = 2,
    parameter int NSETS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_sel,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             touch,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] lru_way;

    if (WAYS == 1) begin : g_direct
        assign lru_way = '0;
    end else if (WAYS == 2) begin : g_pair
        // one bit per set naming the way to evict next
        logic lru_q [NSETS];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < NSETS; s++) lru_q[s] <= 1'b0;
            end else if (touch) begin
                lru_q[set_sel] <= ~touch_way[0];
            end
        end
        assign lru_way = WAY_W'(lru_q[set_sel]);
    end else begin : g_age
        // per-set age ordering, 0 = most recent, WAYS-1 = oldest
        logic [WAY_W-1:0] age_q [NSETS][WAYS];
        logic [WAYS-1:0]  oldest;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < NSETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[s][w] <= WAY_W'(w);
            end else if (touch) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        age_q[set_sel][w] <= '0;
                    else if (age_q[set_sel][w] < age_q[set_sel][touch_way])
                        age_q[set_sel][w] <= age_q[set_sel][w] + WAY_W'(1);
                end
            end
        end
        always_comb begin
            lru_way = '0;
            for (int w = 0; w < WAYS; w++) begin
                oldest[w] = (age_q[set_sel][w] == WAY_W'(WAYS - 1));
                if (oldest[w]) lru_way = WAY_W'(w);
            end
        end
        // R6: exactly one way of the selected set is the eviction candidate
        assert_age_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oldest) == 1);
    end

    // free way first (lowest index), otherwise least recently used
    always_comb begin
        logic found;
        found  = 1'b0;
        victim = lru_way;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !set_valid[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end

    // R5: a set with room never loses a valid block
    assert_victim_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&set_valid)) |-> !set_valid[victim]);
endmodule

// File: rtl/lru_cache.sv
module lru_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int FRAMES = 4,
    parameter int WAYS   = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int NSETS    = FRAMES / WAYS;
    localparam int SET_BITS = $clog2(NSETS);
    localparam int SET_W    = (SET_BITS > 0) ? SET_BITS : 1;
    localparam int TAG_W    = ADDR_W - SET_BITS;
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;

    cache_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    logic [TAG_W-1:0]  tag_q  [NSETS][WAYS];
    logic [DATA_W-1:0] data_q [NSETS][WAYS];
    logic [WAYS-1:0]   valid_q [NSETS];

    logic [SET_W-1:0]            cur_set;
    logic [TAG_W-1:0]            cur_tag;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [WAYS-1:0]             set_valid;
    logic [WAY_W-1:0]            hit_way;
    logic                        any_hit;
    logic [WAY_W-1:0]            victim;
    logic                        touch;
    logic [WAY_W-1:0]            touch_way;
    logic                        fill_we;

    assign cur_set = (SET_BITS > 0) ? addr_q[SET_W-1:0] : '0;
    assign cur_tag = addr_q[ADDR_W-1:SET_BITS];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[cur_set][w];
        set_valid = valid_q[cur_set];
    end

    tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .way_tags  (set_tags),
        .way_valid (set_valid),
        .probe     (cur_tag),
        .hit_way   (hit_way),
        .any_hit   (any_hit)
    );

    repl_policy #(.WAYS(WAYS), .NSETS(NSETS)) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_sel   (cur_set),
        .set_valid (set_valid),
        .touch     (touch),
        .touch_way (touch_way),
        .victim    (victim)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_TAG;
            ST_TAG:  state_d = any_hit ? ST_IDLE : ST_FILL;
            ST_FILL: if (mem_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        rsp_hit   = 1'b0;
        rsp_data  = '0;
        mem_req   = 1'b0;
        touch     = 1'b0;
        touch_way = victim;
        fill_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_TAG: begin
                if (any_hit) begin
                    rsp_hit   = 1'b1;
                    rsp_data  = data_q[cur_set][hit_way];
                    touch     = 1'b1;
                    touch_way = hit_way;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    rsp_hit  = 1'b1;
                    rsp_data = mem_data;
                    touch    = 1'b1;
                    fill_we  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign mem_addr = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else if (state_q == ST_IDLE && req_valid) addr_q <= req_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) valid_q[s] <= '0;
        end else if (fill_we) begin
            valid_q[cur_set][victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[cur_set][victim]  <= cur_tag;
            data_q[cur_set][victim] <= mem_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       miss_count <= '0;
        else if (fill_we) miss_count <= miss_count + CNT_W'(1);
    end

    // R4: the fill request and its address are held until acknowledged
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));
    // R4: a tag miss always leads to a memory request
    assert_miss_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAG && !any_hit) |=> mem_req);
    // R7: counter steps by one per fill and holds otherwise
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (miss_count == $past(miss_count) + CNT_W'(1)));
    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_ack) |=> $stable(miss_count));
endmodule

// File: tb/lru_cache_test.sv
module lru_cache_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done [3];

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pattern(input logic [7:0] a);
        return {a, a ^ 8'hA5};
    endfunction

    for (genvar g = 0; g < 3; g++) begin : g_cfg
        localparam int WAYS  = (g == 0) ? 1 : (g == 1) ? 2 : 4;
        localparam int NSETS = 4 / WAYS;
        localparam logic [4:0] SEQ_MISS = (g == 0) ? 5'b11111 :
                                          (g == 1) ? 5'b11011 : 5'b01011;

        logic        req_valid = 1'b0;
        logic [7:0]  req_addr = '0;
        logic        rsp_hit;
        logic [15:0] rsp_data;
        logic        mem_req;
        logic [7:0]  mem_addr;
        logic        mem_ack;
        logic [15:0] mem_data;
        logic [15:0] miss_count;
        int          wait_cnt;
        logic [7:0]  model_q [NSETS][$];
        int          exp_misses = 0;

        lru_cache #(.ADDR_W(8), .DATA_W(16), .FRAMES(4), .WAYS(WAYS), .CNT_W(16)) uut (
            .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
            .rsp_hit(rsp_hit), .rsp_data(rsp_data), .mem_req(mem_req),
            .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
            .miss_count(miss_count)
        );

        // backing memory with address-dependent latency
        always @(posedge clk) begin
            if (!rst_n) begin
                mem_ack  <= 1'b0;
                mem_data <= '0;
                wait_cnt <= 0;
            end else if (mem_req && !mem_ack) begin
                if (wait_cnt >= int'(mem_addr[1:0]) + g) begin
                    mem_ack  <= 1'b1;
                    mem_data <= pattern(mem_addr);
                    wait_cnt <= 0;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end else begin
                mem_ack  <= 1'b0;
                wait_cnt <= 0;
            end
        end

        task automatic access(input logic [7:0] a, output bit got_miss);
            int  s;
            int  idx;
            int  cyc;
            bit  exp_miss;
            s   = int'(a) % NSETS;
            idx = -1;
            for (int i = 0; i < model_q[s].size(); i++)
                if (model_q[s][i] == a) idx = i;
            exp_miss = (idx < 0);
            if (!exp_miss) model_q[s].delete(idx);
            else if (model_q[s].size() == WAYS) void'(model_q[s].pop_back());
            model_q[s].push_front(a);
            if (exp_miss) exp_misses++;

            got_miss  = 1'b0;
            cyc       = 0;
            req_valid = 1'b1;
            req_addr  = a;
            forever begin
                @(negedge clk);
                cyc++;
                if (mem_req) begin
                    if (!got_miss)
                        check(mem_addr == a, "R4", "fill address", 32'(mem_addr), 32'(a));
                    got_miss = 1'b1;
                    if (!mem_ack)
                        check(!rsp_hit, "R4", "response before ack", 32'(rsp_hit), 32'd0);
                end
                if (rsp_hit || cyc > 40) break;
            end
            req_valid = 1'b0;
            check(got_miss == exp_miss, "R2/R5/R6", "miss flag", 32'(got_miss), 32'(exp_miss));
            check(rsp_data == pattern(a), got_miss ? "R4" : "R3", "returned data",
                  32'(rsp_data), 32'(pattern(a)));
            if (!got_miss)
                check(cyc == 1, "R3", "hit latency", 32'(cyc), 32'd1);
            @(negedge clk);
            check(miss_count == 16'(exp_misses), "R7", "miss count",
                  32'(miss_count), 32'(exp_misses));
        endtask

        initial begin
            logic [7:0] lf;
            logic [7:0] a;
            bit m;
            lf = 8'h5A + 8'(g);
            @(posedge rst_n);
            @(negedge clk);
            check(!rsp_hit, "R1", "rsp_hit after reset", 32'(rsp_hit), 32'd0);
            check(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
            check(miss_count == 16'd0, "R1", "miss_count after reset", 32'(miss_count), 32'd0);
            // R8: fixed sequence 0, 8, 0, 6, 8
            for (int i = 0; i < 5; i++) begin
                case (i)
                    0, 2:    a = 8'd0;
                    1, 4:    a = 8'd8;
                    default: a = 8'd6;
                endcase
                access(a, m);
                check(m == SEQ_MISS[i], "R8", "sequence outcome", 32'(m), 32'(SEQ_MISS[i]));
            end
            // R2/R5/R6: conflict-heavy pseudo-random stream
            for (int i = 0; i < 200; i++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                a  = (lf[7:6] == 2'b00) ? lf : {4'h0, lf[3:0]};
                access(a, m);
            end
            done[g] = 1'b1;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait (done[0] && done[1] && done[2]);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule